// File: doc/BRIEF.md
# Memory Pattern Fill-Verify Engine

This block is a hardware sequencer that checks a memory region for stuck, coupled or aliased cells. It drives a memory port that accepts one request at a time. For each test window it runs seven passes. Each pass first writes every 32-bit word of the window with a pattern, then reads every word back and compares it with the same pattern. Three of the passes derive their pattern from the word's position inside the window. The other four use fixed words. The run stops at the first word that reads back wrong, and the block then reports the address, the expected word and the word actually read.

Two coverage modes are available. Full mode treats the whole region as one window. Sparse mode examines only a small window just above and just below each segment boundary. With default parameters these are 2 KiB windows at each 1 MiB boundary, which keeps the run short on large memories.

A keep-alive pulse is produced at regular word intervals and between passes. A supervising timer can use it to see that a long run is still making progress.

Top module: `mem_sweep_engine`

## Requirements
- R1: The passes run in a fixed order. The pattern for word index k is:
  - pass 0 writes 0x00000000
  - pass 1 writes 0xFFFFFFFF
  - pass 2 writes 0x55555555
  - pass 3 writes 0xAAAAAAAA
  - pass 4 writes 1 << (k mod 32)
  - pass 5 writes k
  - pass 6 writes the bitwise inverse of k
- R2: In every pass, the block first writes all words of the window at ascending word-aligned addresses (window base + 4k). It then reads the same addresses back in the same order.
- R3: When a read word differs from the pattern, the block raises `fail` and latches three values: the address, the expected word and the read word. It then issues no further request and ends the run.
- R4: In sparse mode (`sparse_mode`=1 at start) the segment count is size >> SEG_SHIFT. Each segment s gets two windows of WIN_BYTES bytes, tested in this order:
  - first the window at base + s·2^SEG_SHIFT
  - then the window at base + s·2^SEG_SHIFT + 2^SEG_SHIFT − WIN_BYTES
  - All seven passes complete on one window before the next window starts.
- R5: The word index k used by the position-based patterns restarts at 0 in each window.
- R6: In full mode (`sparse_mode`=0) there is exactly one window. It starts at base and holds size >> 2 words.
- R7: `keepalive` pulses for one cycle in two cases:
  - one cycle after a request is accepted whose word index is a multiple of 2^KA_LOG2
  - once after each completed verify phase
- R8: Mode, base address and size are captured when `start` is seen while idle. Later changes to these inputs do not affect the run.
- R9: `done` is high for exactly one cycle per run. A region holding no window finishes with `done`, no memory request and `fail`=0.
- R10: Only one request is outstanding at a time. After a read is accepted, no new request is made until `mem_rvalid` returns the data, and the comparison uses that returned word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a run (sampled while idle) |
| sparse_mode | input | 1 | 1 selects boundary windows, 0 the whole region |
| base_addr | input | ADDR_W | Byte address of the region start |
| size_bytes | input | ADDR_W | Region size in bytes |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | 1 for write, 0 for read |
| mem_addr | output | ADDR_W | Word-aligned byte address |
| mem_wdata | output | 32 | Write data |
| mem_ready | input | 1 | Request accepted this cycle |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |
| done | output | 1 | One-cycle end-of-run pulse |
| fail | output | 1 | Run stopped on a mismatch (held until next start) |
| fail_addr | output | ADDR_W | Address of the failing word |
| fail_expected | output | 32 | Pattern that was expected |
| fail_read | output | 32 | Word that was read |
| keepalive | output | 1 | Progress pulse |

## Verification
The bench builds the engine with a segment shift of 7 (128-byte segments), 16-byte windows and a keep-alive interval of 4 words. With these settings a full-mode run of 16 words, and a sparse run of three segments with six windows, each finish in a few hundred requests. At the same time they still cover window wrap-around, index restart per window, and several keep-alive intervals within a pass. Injected stuck bits in the memory model place the first mismatch in a mid-run pass of full mode and in the fourth window of sparse mode.

// File: rtl/mem_sweep_pkg.sv
package mem_sweep_pkg;

  localparam int unsigned NUM_PASSES = 7;
  localparam int unsigned PASS_W     = 3;
  localparam logic [PASS_W-1:0] LAST_PASS = PASS_W'(NUM_PASSES - 1);
  localparam logic [PASS_W-1:0] WALK_PASS = 3'd4;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CHECK,
    ST_FILL,
    ST_READ,
    ST_RWAIT,
    ST_GAP,
    ST_DONE
  } sweep_state_e;

endpackage

// File: rtl/mem_sweep_pattern.sv
module mem_sweep_pattern
  import mem_sweep_pkg::*;
(
  input  logic [PASS_W-1:0] pass_sel,
  input  logic [31:0]       word_idx,
  output logic [31:0]       word_out
);

  always_comb begin
    case (pass_sel)
      3'd0:    word_out = 32'h0000_0000;
      3'd1:    word_out = 32'hFFFF_FFFF;
      3'd2:    word_out = 32'h5555_5555;
      3'd3:    word_out = 32'hAAAA_AAAA;
      3'd4:    word_out = 32'd1 << word_idx[4:0];
      3'd5:    word_out = word_idx;
      3'd6:    word_out = ~word_idx;
      default: word_out = 32'h0000_0000;
    endcase
  end

endmodule

// File: rtl/mem_sweep_window.sv
module mem_sweep_window #(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned SEG_SHIFT = 20,
  parameter int unsigned WIN_BYTES = 2048
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              step,
  input  logic              sparse_in,
  input  logic [ADDR_W-1:0] base_in,
  input  logic [ADDR_W-1:0] size_in,
  output logic [ADDR_W-1:0] win_base,
  output logic [ADDR_W-1:0] win_words,
  output logic              win_last,
  output logic              win_empty
);

  localparam logic [ADDR_W-1:0] FAR_OFS   = ADDR_W'((64'd1 << SEG_SHIFT) - 64'(WIN_BYTES));
  localparam logic [ADDR_W-1:0] WIN_WORDS = ADDR_W'(WIN_BYTES / 4);

  logic              sparse_q, sparse_d;
  logic [ADDR_W-1:0] base_q, base_d;
  logic [ADDR_W-1:0] size_q, size_d;
  logic [ADDR_W-1:0] cnt_q, cnt_d;
  logic              cfg_en, cnt_en;

  logic [ADDR_W-1:0] seg_cnt, win_total, seg_base;

  assign cfg_en = load;
  assign cnt_en = load | step;

  always_comb begin
    sparse_d = sparse_in;
    base_d   = base_in;
    size_d   = size_in;
    cnt_d    = load ? '0 : cnt_q + ADDR_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sparse_q <= 1'b0;
      base_q   <= '0;
      size_q   <= '0;
    end else if (cfg_en) begin
      sparse_q <= sparse_d;
      base_q   <= base_d;
      size_q   <= size_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  always_comb begin
    seg_cnt   = size_q >> SEG_SHIFT;
    win_total = sparse_q ? (seg_cnt << 1) : ADDR_W'(1);
    seg_base  = base_q + ((cnt_q >> 1) << SEG_SHIFT);
    win_base  = sparse_q ? (seg_base + (cnt_q[0] ? FAR_OFS : '0)) : base_q;
    win_words = sparse_q ? WIN_WORDS : (size_q >> 2);
    win_empty = sparse_q ? (seg_cnt == '0) : ((size_q >> 2) == '0);
    win_last  = ((cnt_q + ADDR_W'(1)) == win_total);
  end

  // R6: full mode never leaves its single window
  a_r6_single_window: assert property (@(posedge clk) disable iff (!rst_n)
    !sparse_q |-> (cnt_q == '0));

  // R4: a step only happens while a further window exists
  a_r4_step_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load) |-> !win_last);

endmodule

// File: rtl/mem_sweep_engine.sv
module mem_sweep_engine
  import mem_sweep_pkg::*;
#(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned SEG_SHIFT = 20,
  parameter int unsigned WIN_BYTES = 2048,
  parameter int unsigned KA_LOG2   = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              sparse_mode,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic [ADDR_W-1:0] size_bytes,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic              mem_ready,
  input  logic              mem_rvalid,
  input  logic [31:0]       mem_rdata,
  output logic              done,
  output logic              fail,
  output logic [ADDR_W-1:0] fail_addr,
  output logic [31:0]       fail_expected,
  output logic [31:0]       fail_read,
  output logic              keepalive
);

  sweep_state_e      state_q, state_d;
  logic [PASS_W-1:0] pass_q, pass_d;
  logic [ADDR_W-1:0] idx_q, idx_d;
  logic              seq_en;

  logic              fail_q;
  logic [ADDR_W-1:0] faddr_q;
  logic [31:0]       fexp_q, fgot_q;
  logic              fail_set, fail_clr, fail_en;

  logic              ka_q, ka_d;

  logic              win_load, win_step, win_last, win_empty;
  logic [ADDR_W-1:0] win_base, win_words;
  logic [31:0]       pat_word;
  logic              idx_last, accept;

  mem_sweep_window #(
    .ADDR_W   (ADDR_W),
    .SEG_SHIFT(SEG_SHIFT),
    .WIN_BYTES(WIN_BYTES)
  ) u_window (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (win_load),
    .step     (win_step),
    .sparse_in(sparse_mode),
    .base_in  (base_addr),
    .size_in  (size_bytes),
    .win_base (win_base),
    .win_words(win_words),
    .win_last (win_last),
    .win_empty(win_empty)
  );

  mem_sweep_pattern u_pattern (
    .pass_sel(pass_q),
    .word_idx(32'(idx_q)),
    .word_out(pat_word)
  );

  assign idx_last  = (idx_q == (win_words - ADDR_W'(1)));
  assign mem_req   = (state_q == ST_FILL) || (state_q == ST_READ);
  assign mem_we    = (state_q == ST_FILL);
  assign mem_addr  = win_base + (idx_q << 2);
  assign mem_wdata = pat_word;
  assign accept    = mem_req && mem_ready;

  always_comb begin
    state_d  = state_q;
    pass_d   = pass_q;
    idx_d    = idx_q;
    win_load = 1'b0;
    win_step = 1'b0;
    fail_set = 1'b0;
    fail_clr = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start) begin
          win_load = 1'b1;
          fail_clr = 1'b1;
          state_d  = ST_CHECK;
        end
      end
      ST_CHECK: begin
        pass_d  = '0;
        idx_d   = '0;
        state_d = win_empty ? ST_DONE : ST_FILL;
      end
      ST_FILL: begin
        if (mem_ready) begin
          if (idx_last) begin
            idx_d   = '0;
            state_d = ST_READ;
          end else begin
            idx_d = idx_q + ADDR_W'(1);
          end
        end
      end
      ST_READ: begin
        if (mem_ready) state_d = ST_RWAIT;
      end
      ST_RWAIT: begin
        if (mem_rvalid) begin
          if (mem_rdata != pat_word) begin
            fail_set = 1'b1;
            state_d  = ST_DONE;
          end else if (idx_last) begin
            idx_d   = '0;
            state_d = ST_GAP;
          end else begin
            idx_d   = idx_q + ADDR_W'(1);
            state_d = ST_READ;
          end
        end
      end
      ST_GAP: begin
        if (pass_q == LAST_PASS) begin
          if (win_last) begin
            state_d = ST_DONE;
          end else begin
            win_step = 1'b1;
            pass_d   = '0;
            state_d  = ST_FILL;
          end
        end else begin
          pass_d  = pass_q + PASS_W'(1);
          state_d = ST_FILL;
        end
      end
      ST_DONE:  state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  assign seq_en = (state_q != ST_IDLE) || start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      pass_q  <= '0;
      idx_q   <= '0;
    end else if (seq_en) begin
      state_q <= state_d;
      pass_q  <= pass_d;
      idx_q   <= idx_d;
    end
  end

  assign fail_en = fail_set || fail_clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fail_q  <= 1'b0;
      faddr_q <= '0;
      fexp_q  <= '0;
      fgot_q  <= '0;
    end else if (fail_en) begin
      fail_q  <= fail_set;
      faddr_q <= fail_set ? mem_addr  : '0;
      fexp_q  <= fail_set ? pat_word  : '0;
      fgot_q  <= fail_set ? mem_rdata : '0;
    end
  end

  assign ka_d = (accept && (idx_q[KA_LOG2-1:0] == '0)) || (state_q == ST_GAP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ka_q <= 1'b0;
    else        ka_q <= ka_d;
  end

  assign done          = (state_q == ST_DONE);
  assign fail          = fail_q;
  assign fail_addr     = faddr_q;
  assign fail_expected = fexp_q;
  assign fail_read     = fgot_q;
  assign keepalive     = ka_q;

  // R10: an accepted read blocks further requests until data returns
  a_r10_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we && mem_ready) |=> !mem_req);

  // R9: done lasts a single cycle
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R3: a new failure is always reported together with done
  a_r3_fail_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fail) |-> done);

  // R3: after done the port stays quiet until a new start
  a_r3_quiet_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !mem_req);

  // R2: requests are word aligned
  a_r2_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_addr[1:0] == 2'b00));

  // R1: the walking pass writes a single set bit
  a_r1_walk_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && (pass_q == WALK_PASS)) |-> $onehot(mem_wdata));

endmodule

// File: tb/sim_mem_sweep_engine.sv
`timescale 1ns/1ps
module sim_mem_sweep_engine;

  localparam int SEG_SHIFT = 7;
  localparam int WIN_BYTES = 16;
  localparam int KA_LOG2   = 2;

  typedef struct {
    logic        we;
    logic [31:0] addr;
    logic [31:0] data;
  } txn_t;

  logic        clk, rst_n, start, sparse_mode;
  logic [31:0] base_addr, size_bytes;
  logic        mem_req, mem_we, mem_ready, mem_rvalid;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        done, fail, keepalive;
  logic [31:0] fail_addr, fail_expected, fail_read;

  mem_sweep_engine #(
    .ADDR_W(32), .SEG_SHIFT(SEG_SHIFT), .WIN_BYTES(WIN_BYTES), .KA_LOG2(KA_LOG2)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .sparse_mode(sparse_mode),
    .base_addr(base_addr), .size_bytes(size_bytes),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ready(mem_ready), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .done(done), .fail(fail), .fail_addr(fail_addr), .fail_expected(fail_expected),
    .fail_read(fail_read), .keepalive(keepalive)
  );

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  txn_t        sb_q[$];
  logic [31:0] mem_model [logic [31:0]];
  logic [31:0] flt_addr, flt_s0, flt_s1;
  int          ka_cnt, done_cnt, txn_no, pend;
  logic [31:0] pend_addr;

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_pat(int p, int k);
    case (p)
      0: return 32'h0000_0000;
      1: return 32'hFFFF_FFFF;
      2: return 32'h5555_5555;
      3: return 32'hAAAA_AAAA;
      4: return 32'd1 << (k % 32);
      5: return 32'(k);
      default: return ~32'(k);
    endcase
  endfunction

  // Driver side of the scoreboard: expected request stream (R1 R2 R4 R5 R6)
  task automatic push_run(bit sp, logic [31:0] base, logic [31:0] size,
                          int stop_pass, logic [31:0] stop_addr, output int ka_exp);
    int nwin, words;
    logic [31:0] wb;
    ka_exp = 0;
    nwin  = sp ? 2 * int'(size >> SEG_SHIFT) : (((size >> 2) != 0) ? 1 : 0);
    words = sp ? WIN_BYTES / 4 : int'(size >> 2);
    for (int w = 0; w < nwin; w++) begin
      wb = sp ? base + 32'((w / 2) << SEG_SHIFT) + ((w % 2) ? 32'((1 << SEG_SHIFT) - WIN_BYTES) : 32'd0)
              : base;
      for (int p = 0; p < 7; p++) begin
        for (int k = 0; k < words; k++) begin
          sb_q.push_back('{1'b1, wb + 32'(4 * k), exp_pat(p, k)});
          if (k % (1 << KA_LOG2) == 0) ka_exp++;
        end
        for (int k = 0; k < words; k++) begin
          sb_q.push_back('{1'b0, wb + 32'(4 * k), exp_pat(p, k)});
          if (k % (1 << KA_LOG2) == 0) ka_exp++;
          if (p == stop_pass && (wb + 32'(4 * k)) == stop_addr) return;
        end
        ka_exp++;
      end
    end
  endtask

  // Memory model and monitor side of the scoreboard (R10)
  always @(negedge clk) begin
    if (!rst_n) begin
      mem_ready  <= 1'b0;
      mem_rvalid <= 1'b0;
      pend       = 0;
    end else begin
      mem_rvalid <= 1'b0;
      if (pend > 0) begin
        pend--;
        if (pend == 0) begin
          mem_rvalid <= 1'b1;
          mem_rdata  <= ((mem_model.exists(pend_addr) ? mem_model[pend_addr] : 32'h0)
                         & ~((pend_addr == flt_addr) ? flt_s0 : 32'h0))
                         | ((pend_addr == flt_addr) ? flt_s1 : 32'h0);
        end
      end
      txn_no++;
      mem_ready = (txn_no % 3) != 0;
      if (keepalive) ka_cnt++;
      if (done) done_cnt++;
      if (mem_req && mem_ready) begin
        if (sb_q.size() == 0) begin
          check("R3 unexpected request addr", mem_addr, 32'hDEAD_BEEF);
        end else begin
          txn_t t;
          t = sb_q.pop_front();
          check("R2 request direction", 32'(mem_we), 32'(t.we));
          check("R2/R4 request address", mem_addr, t.addr);
          if (t.we) begin
            check("R1/R5 write data", mem_wdata, t.data);
            mem_model[mem_addr] = mem_wdata;
          end else begin
            pend_addr = mem_addr;
            pend      = 1 + (txn_no % 2);
          end
        end
      end
    end
  end

  task automatic run(bit sp, logic [31:0] base, logic [31:0] size);
    ka_cnt   = 0;
    done_cnt = 0;
    @(negedge clk);
    start       = 1'b1;
    sparse_mode = sp;
    base_addr   = base;
    size_bytes  = size;
    @(negedge clk);
    start       = 1'b0;
    // R8: disturb configuration inputs after start
    sparse_mode = ~sp;
    base_addr   = 32'hFFFF_0000;
    size_bytes  = 32'h0000_4000;
    while (done_cnt == 0) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  initial begin
    int ka_exp;
    rst_n = 1'b0; start = 1'b0; sparse_mode = 1'b0;
    base_addr = '0; size_bytes = '0;
    flt_addr = 32'hFFFF_FFFC; flt_s0 = '0; flt_s1 = '0;
    txn_no = 0;
    repeat (3) @(negedge clk);
    check("R9 reset done", 32'(done), 32'd0);
    check("R3 reset fail", 32'(fail), 32'd0);
    check("R10 reset req", 32'(mem_req), 32'd0);
    check("R7 reset keepalive", 32'(keepalive), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // Full mode, clean memory: R1 R2 R6 R7 R8 R9
    push_run(1'b0, 32'h1000, 32'd64, 99, 32'h0, ka_exp);
    run(1'b0, 32'h1000, 32'd64);
    check("R2 all expected requests seen", 32'(sb_q.size()), 32'd0);
    check("R3 clean full run fail", 32'(fail), 32'd0);
    check("R9 done pulse count full", 32'(done_cnt), 32'd1);
    check("R7 keepalive count full", 32'(ka_cnt), 32'(ka_exp));

    // Sparse mode, clean memory: R4 R5 R7 R8
    push_run(1'b1, 32'h2000, 32'd384, 99, 32'h0, ka_exp);
    run(1'b1, 32'h2000, 32'd384);
    check("R4 all expected sparse requests seen", 32'(sb_q.size()), 32'd0);
    check("R3 clean sparse run fail", 32'(fail), 32'd0);
    check("R9 done pulse count sparse", 32'(done_cnt), 32'd1);
    check("R7 keepalive count sparse", 32'(ka_cnt), 32'(ka_exp));

    // Full mode, bit 3 stuck low at 0x1008: stops in pass 1 (R3)
    flt_addr = 32'h1008; flt_s0 = 32'h8; flt_s1 = 32'h0;
    push_run(1'b0, 32'h1000, 32'd64, 1, 32'h1008, ka_exp);
    run(1'b0, 32'h1000, 32'd64);
    check("R3 stopped after first mismatch", 32'(sb_q.size()), 32'd0);
    check("R3 fail flag", 32'(fail), 32'd1);
    check("R3 fail address", fail_addr, 32'h1008);
    check("R3 fail expected", fail_expected, 32'hFFFF_FFFF);
    check("R3 fail read", fail_read, 32'hFFFF_FFF7);
    check("R9 done pulse count on fail", 32'(done_cnt), 32'd1);

    // Sparse mode, bit 0 stuck high in fourth window (R3 R4)
    flt_addr = 32'h20F4; flt_s0 = 32'h0; flt_s1 = 32'h1;
    push_run(1'b1, 32'h2000, 32'd384, 0, 32'h20F4, ka_exp);
    run(1'b1, 32'h2000, 32'd384);
    check("R4 stopped in boundary window", 32'(sb_q.size()), 32'd0);
    check("R3 sparse fail flag", 32'(fail), 32'd1);
    check("R3 sparse fail address", fail_addr, 32'h20F4);
    check("R3 sparse fail expected", fail_expected, 32'h0);
    check("R3 sparse fail read", fail_read, 32'h1);

    // Empty regions: R9
    flt_addr = 32'hFFFF_FFFC; flt_s1 = 32'h0;
    run(1'b1, 32'h3000, 32'd100);
    check("R9 empty sparse done", 32'(done_cnt), 32'd1);
    check("R9 empty sparse clears fail", 32'(fail), 32'd0);
    check("R9 empty sparse keepalive", 32'(ka_cnt), 32'd0);
    run(1'b0, 32'h3000, 32'd0);
    check("R9 empty full done", 32'(done_cnt), 32'd1);
    check("R9 empty full fail", 32'(fail), 32'd0);

    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog R9 actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

endmodule